// File: doc/BRIEF.md
# Cascaded Result Address Driver

This block is the output stage that presents a 13-bit result address from one device in a vertical chain of lookup devices. Each memory cycle ends with an address for the stage to show. That address is a match location, the next free location, or the location of a plain random access. A small state machine records what kind of result the last cycle left behind. That record decides whether the stage drives its result port.

After a random access, the port is driven only while the device's active-low output enable is asserted. After a lookup-type cycle, the output enable is ignored and cascade priority decides instead. The device with the highest priority among those holding a result drives its address. When no device holds a result after a compare or a next-free write, the lowest-priority device drives all ones. Every other device stays undriven.

A new cycle result is first staged in a pending register. It reaches the port only at a clock edge where the active-low strobe is high. This keeps the presented address frozen while a cycle is in progress.

Top module: `cascade_addr_driver`

## Requirements
- R1: After reset the presented address is 0 and the last-cycle class is ordinary, so `addr_drive` simply follows `oe_n` (high enable gives no drive, low enable gives address 0).
- R2: A cycle of kind `2'b00` (random access) presents its `addr_in` and drives it only while `oe_n` is low. The local hit and cascade inputs have no effect on this kind.
- R3: After a random-access cycle, `addr_drive` is 0 whenever `oe_n` is high.
- R4: After a lookup-type cycle (kind `2'b01` compare, `2'b10` write at next free, `2'b11` read/write at best match), a device with `local_hit` set and `higher_has_result` clear drives its `addr_in`, whatever `oe_n` is.
- R5: After a lookup-type cycle, a device whose `higher_has_result` is set does not drive, even with `local_hit` set and `oe_n` low.
- R6: After a compare or next-free write, a device with `lowest_prio` set, `local_hit` clear and `higher_has_result` clear drives all ones (`13'h1FFF`), whatever `oe_n` is.
- R7: After a lookup-type cycle, a device with `local_hit` clear and `lowest_prio` clear does not drive.
- R8: After a best-match read/write (kind `2'b11`) where no device has a result, no device drives, including the lowest-priority one.
- R9: A cycle captured with `cyc_valid` becomes pending at that clock edge. It reaches the port at the first later edge where `strobe_n` is high. While `strobe_n` is low, the presented address and class do not change.
- R10: When several cycles are captured while `strobe_n` stays low, only the last one is presented once the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Active-low cycle strobe; presented value updates only while high |
| cyc_valid | input | 1 | A memory cycle completes this edge |
| cyc_kind | input | 2 | Cycle kind: 00 random, 01 compare, 10 next-free write, 11 best-match read/write |
| addr_in | input | 13 | Address resolved by this device for the cycle |
| local_hit | input | 1 | This device has a match or a free slot |
| higher_has_result | input | 1 | Some higher-priority device has a result |
| lowest_prio | input | 1 | This device is last in the chain |
| oe_n | input | 1 | Active-low output enable |
| addr_out | output | 13 | Result address value |
| addr_drive | output | 1 | High when the device drives the shared result bus |

## Verification
The bench wires three devices into a priority chain and resolves the shared bus itself. It counts drivers and forms the wired value. Random-access patterns are run with one enable low, and then with all enables high; these separate enable gating from cascade gating. Compare and next-free patterns use hits in the top, middle or bottom device, or in none. These show whether priority overrides the enable and whether only the last device reports all ones. A best-match miss separates that cycle kind from the other two lookups. Cycles captured under a low strobe, singly and back to back, show holding and last-wins staging.

// File: rtl/cad_pkg.sv
package cad_pkg;

    typedef enum logic [1:0] {
        KIND_RANDOM      = 2'b00,
        KIND_COMPARE     = 2'b01,
        KIND_WRITE_FREE  = 2'b10,
        KIND_MATCH_RW    = 2'b11
    } cyc_kind_e;

    typedef enum logic [1:0] {
        CLS_ORDINARY = 2'b00,
        CLS_OWNER    = 2'b01,
        CLS_DEFER    = 2'b10,
        CLS_MISS     = 2'b11
    } res_cls_e;

endpackage

// File: rtl/cad_resolve.sv
module cad_resolve
    import cad_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr_in,
    input  logic          local_hit,
    input  logic          higher_has_result,
    input  logic          lowest_prio,
    output res_cls_e      nxt_cls,
    output logic [AW-1:0] nxt_addr
);
    cyc_kind_e kind_e;

    always_comb begin
        kind_e   = cyc_kind_e'(kind);
        nxt_addr = addr_in;
        unique case (kind_e)
            KIND_RANDOM: nxt_cls = CLS_ORDINARY;
            KIND_COMPARE, KIND_WRITE_FREE: begin
                if (higher_has_result)  nxt_cls = CLS_DEFER;
                else if (local_hit)     nxt_cls = CLS_OWNER;
                else if (lowest_prio)   nxt_cls = CLS_MISS;
                else                    nxt_cls = CLS_DEFER;
            end
            KIND_MATCH_RW: begin
                if (!higher_has_result && local_hit) nxt_cls = CLS_OWNER;
                else                                 nxt_cls = CLS_DEFER;
            end
            default: nxt_cls = CLS_ORDINARY;
        endcase
    end

endmodule

// File: rtl/cad_fsm.sv
module cad_fsm
    import cad_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_n,
    input  logic          cyc_valid,
    input  res_cls_e      nxt_cls,
    input  logic [AW-1:0] nxt_addr,
    output res_cls_e      state,
    output logic [AW-1:0] held_addr
);
    res_cls_e      pend_cls;
    logic [AW-1:0] pend_addr;
    res_cls_e      next_state;
    logic [AW-1:0] next_addr;

    // staging register: last captured cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cls  <= CLS_ORDINARY;
            pend_addr <= '0;
        end else if (cyc_valid) begin
            pend_cls  <= nxt_cls;
            pend_addr <= nxt_addr;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CLS_ORDINARY;
            held_addr <= '0;
        end else begin
            state     <= next_state;
            held_addr <= next_addr;
        end
    end

    // transitions: every state moves to the pending class when the strobe is high
    always_comb begin
        next_state = state;
        next_addr  = held_addr;
        unique case (state)
            CLS_ORDINARY, CLS_OWNER, CLS_DEFER, CLS_MISS: begin
                if (strobe_n) begin
                    next_state = pend_cls;
                    next_addr  = pend_addr;
                end
            end
            default: next_state = CLS_ORDINARY;
        endcase
    end

endmodule

// File: rtl/cad_drive.sv
module cad_drive
    import cad_pkg::*;
#(
    parameter int AW = 13
) (
    input  res_cls_e      state,
    input  logic [AW-1:0] held_addr,
    input  logic          oe_n,
    output logic [AW-1:0] addr_out,
    output logic          addr_drive
);
    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

    always_comb begin
        addr_out   = held_addr;
        addr_drive = 1'b0;
        unique case (state)
            CLS_ORDINARY: addr_drive = !oe_n;
            CLS_OWNER:    addr_drive = 1'b1;
            CLS_DEFER:    addr_drive = 1'b0;
            CLS_MISS: begin
                addr_drive = 1'b1;
                addr_out   = ALL_ONES;
            end
            default:      addr_drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/cascade_addr_driver.sv
module cascade_addr_driver
    import cad_pkg::*;
#(
    parameter int AW = 13,
    parameter int KW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_n,
    input  logic          cyc_valid,
    input  logic [KW-1:0] cyc_kind,
    input  logic [AW-1:0] addr_in,
    input  logic          local_hit,
    input  logic          higher_has_result,
    input  logic          lowest_prio,
    input  logic          oe_n,
    output logic [AW-1:0] addr_out,
    output logic          addr_drive
);
    res_cls_e      nxt_cls;
    logic [AW-1:0] nxt_addr;
    res_cls_e      cur_cls;
    logic [AW-1:0] held_addr;

    cad_resolve #(.AW(AW)) u_resolve (
        .kind              (cyc_kind[1:0]),
        .addr_in           (addr_in),
        .local_hit         (local_hit),
        .higher_has_result (higher_has_result),
        .lowest_prio       (lowest_prio),
        .nxt_cls           (nxt_cls),
        .nxt_addr          (nxt_addr)
    );

    cad_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (strobe_n),
        .cyc_valid (cyc_valid),
        .nxt_cls   (nxt_cls),
        .nxt_addr  (nxt_addr),
        .state     (cur_cls),
        .held_addr (held_addr)
    );

    cad_drive #(.AW(AW)) u_drive (
        .state      (cur_cls),
        .held_addr  (held_addr),
        .oe_n       (oe_n),
        .addr_out   (addr_out),
        .addr_drive (addr_drive)
    );

endmodule

// File: rtl/cad_checker.sv
module cad_checker
    import cad_pkg::*;
#(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe_n,
    input logic          oe_n,
    input logic [AW-1:0] addr_out,
    input logic          addr_drive,
    input res_cls_e      cur_cls,
    input logic [AW-1:0] held_addr
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (held_addr == '0 && cur_cls == CLS_ORDINARY));

    assert_ordinary_floats_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cls == CLS_ORDINARY && oe_n) |-> !addr_drive);

    assert_owner_ignores_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cls == CLS_OWNER) |-> (addr_drive && addr_out == held_addr));

    assert_deferred_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cls == CLS_DEFER) |-> !addr_drive);

    assert_miss_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cls == CLS_MISS) |-> (addr_drive && addr_out == {AW{1'b1}}));

    assert_hold_under_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> ($stable(held_addr) && $stable(cur_cls)));

endmodule

bind cascade_addr_driver cad_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_n   (strobe_n),
    .oe_n       (oe_n),
    .addr_out   (addr_out),
    .addr_drive (addr_drive),
    .cur_cls    (cur_cls),
    .held_addr  (held_addr)
);

// File: tb/cascade_addr_driver_bench.sv
module cascade_addr_driver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int NV = 12;

    typedef struct packed {
        logic [1:0]    kind;
        logic [2:0]    hits;
        logic [2:0]    oen;
        logic [AW-1:0] base;
        logic [2:0]    mask;
        logic [AW-1:0] bus;
    } vec_t;

    // hits/oen/mask bit i = device i (device 0 highest priority)
    localparam vec_t VECS [NV] = '{
        '{2'b00, 3'b000, 3'b110, 13'h0100, 3'b001, 13'h0100}, // R2
        '{2'b00, 3'b000, 3'b011, 13'h0200, 3'b100, 13'h0202}, // R2
        '{2'b00, 3'b000, 3'b111, 13'h0300, 3'b000, 13'h0000}, // R3
        '{2'b01, 3'b001, 3'b111, 13'h0400, 3'b001, 13'h0400}, // R4
        '{2'b01, 3'b110, 3'b000, 13'h0500, 3'b010, 13'h0501}, // R5
        '{2'b01, 3'b100, 3'b111, 13'h0600, 3'b100, 13'h0602}, // R4 R7
        '{2'b01, 3'b000, 3'b000, 13'h0700, 3'b100, 13'h1FFF}, // R6
        '{2'b10, 3'b000, 3'b111, 13'h0750, 3'b100, 13'h1FFF}, // R6
        '{2'b10, 3'b011, 3'b111, 13'h0800, 3'b001, 13'h0800}, // R5
        '{2'b11, 3'b010, 3'b000, 13'h0900, 3'b010, 13'h0901}, // R4
        '{2'b11, 3'b000, 3'b000, 13'h0950, 3'b000, 13'h0000}, // R8
        '{2'b00, 3'b111, 3'b101, 13'h0A00, 3'b010, 13'h0A01}  // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_n = 1'b1;
    logic          cyc_valid = 1'b0;
    logic [1:0]    kind = 2'b00;
    logic [2:0]    hits = 3'b000;
    logic [2:0]    oen = 3'b111;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] aout [3];
    logic [2:0]    drv;
    int            n_vec = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_addr_driver u_cascade_addr_driver (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .cyc_valid(cyc_valid),
        .cyc_kind(kind), .addr_in(base), .local_hit(hits[0]),
        .higher_has_result(1'b0), .lowest_prio(1'b0), .oe_n(oen[0]),
        .addr_out(aout[0]), .addr_drive(drv[0]));

    cascade_addr_driver u_dev_mid (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .cyc_valid(cyc_valid),
        .cyc_kind(kind), .addr_in(base + 13'd1), .local_hit(hits[1]),
        .higher_has_result(hits[0]), .lowest_prio(1'b0), .oe_n(oen[1]),
        .addr_out(aout[1]), .addr_drive(drv[1]));

    cascade_addr_driver u_dev_low (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .cyc_valid(cyc_valid),
        .cyc_kind(kind), .addr_in(base + 13'd2), .local_hit(hits[2]),
        .higher_has_result(hits[0] | hits[1]), .lowest_prio(1'b1), .oe_n(oen[2]),
        .addr_out(aout[2]), .addr_drive(drv[2]));

    function automatic logic [AW-1:0] bus_value();
        logic [AW-1:0] v = '0;
        for (int i = 0; i < 3; i++) if (drv[i]) v |= aout[i];
        return v;
    endfunction

    task automatic check(input string req, input logic [2:0] emask, input logic [AW-1:0] ebus);
        logic [AW-1:0] b = bus_value();
        n_vec++;
        if (drv !== emask || (emask != 3'b000 && b !== ebus)) begin
            n_bad++;
            $display("FAIL %s: drivers=%b bus=%h expected drivers=%b bus=%h", req, drv, b, emask, ebus);
        end
    endtask

    // capture one cycle with the strobe low; leave strobe low afterwards
    task automatic capture(input logic [1:0] k, input logic [2:0] h, input logic [AW-1:0] a);
        @(negedge clk);
        kind = k; hits = h; base = a; strobe_n = 1'b0; cyc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    task automatic release_strobe();
        strobe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle enables high", 3'b000, '0);
        oen = 3'b110;
        #1;
        check("R1 enable low shows zero", 3'b001, 13'h0000);

        for (int v = 0; v < NV; v++) begin
            oen = VECS[v].oen;
            capture(VECS[v].kind, VECS[v].hits, VECS[v].base);
            release_strobe();
            check($sformatf("vector %0d (R2-R8 table)", v), VECS[v].mask, VECS[v].bus);
        end

        // R9: hold while strobe low
        oen = 3'b111;
        capture(2'b01, 3'b001, 13'h0B00);
        check("R9 held one edge", 3'b000, '0);
        @(posedge clk);
        @(negedge clk);
        check("R9 held two edges", 3'b000, '0);
        release_strobe();
        check("R9 presented after strobe", 3'b001, 13'h0B00);

        // R10: last captured cycle wins
        capture(2'b01, 3'b000, 13'h0C50);
        capture(2'b00, 3'b000, 13'h0C00);
        release_strobe();
        check("R10 last wins, enables high", 3'b000, '0);
        oen = 3'b011;
        #1;
        check("R10 last wins, low device enabled", 3'b100, 13'h0C02);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule